// File: doc/BRIEF.md
# Password Verification Engine with Attempt Counters

This block sits behind a byte-level serial-bus shifter and runs the verify-password transaction. After a start condition the host sends a command byte, then an index byte that picks one stored password, then three password bytes. The block acknowledges each of these bytes. It reads the stored password for the chosen index from an external register file through a select/data port pair. When a stop condition follows the third password byte, the block starts a modelled nonvolatile write cycle. That cycle lasts a fixed, parameterized number of clocks. At its end the attempt counter of the selected password is updated.

Each password, read or write for each set, has its own 8-bit attempt counter. A correct password sets the counter to all ones and grants the matching privilege. A wrong password clears one more bit of the counter. A counter that has reached zero locks its password for good. The host learns when the write cycle has finished by polling a separate device code. The block NACKs that code while the write cycle runs and ACKs it afterwards. The byte after an acknowledged poll is taken as a counter address, and the block returns that counter's value. A separate privilege-clear input removes every granted privilege and leaves the counters as they are.

Top module: `pwd_verify_engine`

## Requirements
- R1: After reset every attempt counter reads 0xFF, all read and write grants are 0, and ack_valid and rd_valid are 0.
- R2: start_evt restarts the sequence from any state. The first byte after a start is a device byte: 0xB4 is ACKed when no write cycle is busy, and any byte other than 0xB4 or 0xB5 is NACKed.
- R3: After 0xB4, the index byte and the three password bytes are each ACKed. Bits 7:4 of the index are ignored. Bit 3 selects the read (1) or write (0) password, and bits 2:0 select the set, so index 0111 is the write password of set 7. pw_sel shows the index bits 3:0. Password byte k is compared with pw_data[8k+7:8k].
- R4: A stop directly after the third password byte starts a write cycle of exactly WR_CYCLES clocks. A poll that lands on the last busy clock is still NACKed.
- R5: On a match the selected counter becomes 0xFF and the grant of that type and set is raised. Grants change only at the end of a write cycle or on priv_clear.
- R6: On a mismatch the selected counter is shifted left by one with a zero shifted in (0xFF, 0xFE, 0xFC, ...).
- R7: A counter at 0x00 neither changes nor grants, even for a correct password.
- R8: While a write cycle is busy, both 0xB5 and 0xB4 device bytes are NACKed.
- R9: When no write cycle is busy, 0xB5 is ACKed. The next byte is ACKed, and its bits 3:0, coded as in R3, select a counter. One clock later rd_valid pulses and rd_data holds that counter's value.
- R10: A stop before the third password byte has been received aborts the transaction. No write cycle starts, so an immediate poll is ACKed, and the counter is unchanged.
- R11: priv_clear clears all read and write grants on the next clock and leaves the counters unchanged.
- R12: Bytes received after the third password byte are NACKed and do not cancel the pending verification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_clear | input | 1 | Clears all granted privileges |
| start_evt | input | 1 | Start condition seen by the shifter |
| stop_evt | input | 1 | Stop condition seen by the shifter |
| byte_valid | input | 1 | A received byte is present |
| byte_data | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision for the previous byte |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| pw_sel | output | 4 | Register-file index of the password to compare |
| pw_data | input | 24 | Stored password for pw_sel, byte 0 in bits 7:0 |
| rd_valid | output | 1 | Counter readout strobe |
| rd_data | output | 8 | Counter value read out |
| rd_grant | output | 8 | Read privilege per set |
| wr_grant | output | 8 | Write privilege per set |

## Verification
The bench keeps the default of eight sets, so all sixteen counters are swept: each gets a correct verification, a readout and a grant check. It overrides WR_CYCLES to 6. With this short cycle, one password can be driven through all eight lockout steps down to 0x00 and then checked under a correct password within a small run. The short cycle also puts the last busy clock, and the first clock when polling is answered, at a known offset from the stop, so both can be hit exactly.

// File: rtl/pwd_verify_pkg.sv
package pwd_verify_pkg;
  localparam int PW_BYTES = 3;
  localparam int PW_W     = 8 * PW_BYTES;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_IDX, ST_PW0, ST_PW1, ST_PW2, ST_FULL, ST_POLL, ST_IGN
  } seq_state_e;
endpackage

// File: rtl/pwd_seq.sv
module pwd_seq
  import pwd_verify_pkg::*;
#(
  parameter int         IDX_W    = 4,
  parameter logic [7:0] CMD_CODE = 8'hB4,
  parameter logic [7:0] POLL_CODE = 8'hB5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             busy,
  output logic             ack_valid,
  output logic             ack,
  output logic [IDX_W-1:0] idx,
  output logic [PW_W-1:0]  pw_rx,
  output logic             launch,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_addr,
  output logic             dev_phase
);
  seq_state_e state_q, state_d;
  logic ack_valid_q, ack_valid_d, ack_q, ack_d;
  logic [IDX_W-1:0] idx_q;
  logic [PW_W-1:0]  pw_q;
  logic             idx_en;
  logic [PW_BYTES-1:0] pw_en;

  always_comb begin
    state_d     = state_q;
    ack_valid_d = 1'b0;
    ack_d       = 1'b0;
    launch      = 1'b0;
    rd_req      = 1'b0;
    idx_en      = 1'b0;
    pw_en       = '0;
    if (start_evt) begin
      state_d = ST_DEV;
    end else if (stop_evt) begin
      launch  = (state_q == ST_FULL);
      state_d = ST_IDLE;
    end else if (byte_valid) begin
      ack_valid_d = 1'b1;
      unique case (state_q)
        ST_DEV: begin
          if (byte_data == CMD_CODE && !busy) begin
            ack_d = 1'b1; state_d = ST_IDX;
          end else if (byte_data == POLL_CODE && !busy) begin
            ack_d = 1'b1; state_d = ST_POLL;
          end else begin
            state_d = ST_IGN;
          end
        end
        ST_IDX:  begin ack_d = 1'b1; idx_en = 1'b1;   state_d = ST_PW0;  end
        ST_PW0:  begin ack_d = 1'b1; pw_en[0] = 1'b1; state_d = ST_PW1;  end
        ST_PW1:  begin ack_d = 1'b1; pw_en[1] = 1'b1; state_d = ST_PW2;  end
        ST_PW2:  begin ack_d = 1'b1; pw_en[2] = 1'b1; state_d = ST_FULL; end
        ST_POLL: begin ack_d = 1'b1; rd_req = 1'b1;   state_d = ST_IGN;  end
        default: ack_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ack_valid_q <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      ack_valid_q <= ack_valid_d;
      ack_q       <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_en) idx_q <= byte_data[IDX_W-1:0];
  end

  for (genvar k = 0; k < PW_BYTES; k++) begin : g_pw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pw_q[8*k +: 8] <= '0;
      else if (pw_en[k]) pw_q[8*k +: 8] <= byte_data;
    end
  end

  assign ack_valid = ack_valid_q;
  assign ack       = ack_q;
  assign idx       = idx_q;
  assign pw_rx     = pw_q;
  assign rd_addr   = byte_data[IDX_W-1:0];
  assign dev_phase = (state_q == ST_DEV);
endmodule

// File: rtl/pwd_wr_timer.sv
module pwd_wr_timer #(
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (launch) cnt_d = CNT_W'(WR_CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pwd_pac_store.sv
module pwd_pac_store #(
  parameter int NPAC  = 16,
  parameter int IDX_W = 4,
  parameter int PAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [IDX_W-1:0] launch_idx,
  input  logic             launch_match,
  input  logic             done,
  input  logic             priv_clear,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_addr,
  output logic             rd_valid,
  output logic [PAC_W-1:0] rd_data,
  output logic [NPAC-1:0]  grant
);
  logic [PAC_W-1:0] pac_q [NPAC];
  logic [PAC_W-1:0] pac_d [NPAC];
  logic [IDX_W-1:0] pend_q;
  logic             pend_ok_q;
  logic [NPAC-1:0]  grant_q, grant_d;
  logic             rd_valid_q;
  logic [PAC_W-1:0] rd_data_q;

  always_comb begin
    for (int i = 0; i < NPAC; i++) pac_d[i] = pac_q[i];
    grant_d = grant_q;
    if (done) begin
      if (pend_ok_q) begin
        pac_d[pend_q]   = '1;
        grant_d[pend_q] = 1'b1;
      end else begin
        pac_d[pend_q] = pac_q[pend_q] << 1;
      end
    end
    if (priv_clear) grant_d = '0;
  end

  for (genvar i = 0; i < NPAC; i++) begin : g_pac
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pac_q[i] <= '1;
      else pac_q[i] <= pac_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      pend_ok_q <= 1'b0;
    end else if (launch) begin
      pend_q    <= launch_idx;
      pend_ok_q <= launch_match && (pac_q[launch_idx] != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      grant_q    <= grant_d;
      rd_valid_q <= rd_req;
      if (rd_req) rd_data_q <= pac_q[rd_addr];
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign grant    = grant_q;
endmodule

// File: rtl/pwd_verify_engine.sv
module pwd_verify_engine
  import pwd_verify_pkg::*;
#(
  parameter int NSETS     = 8,
  parameter int PAC_W     = 8,
  parameter int WR_CYCLES = 200,
  localparam int SET_W    = $clog2(NSETS),
  localparam int IDX_W    = SET_W + 1,
  localparam int NPAC     = 2 * NSETS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_clear,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             ack_valid,
  output logic             ack,
  output logic [IDX_W-1:0] pw_sel,
  input  logic [PW_W-1:0]  pw_data,
  output logic             rd_valid,
  output logic [PAC_W-1:0] rd_data,
  output logic [NSETS-1:0] rd_grant,
  output logic [NSETS-1:0] wr_grant
);
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic             busy, done, launch, rd_req, dev_phase;
  logic [IDX_W-1:0] idx, rd_addr;
  logic [PW_W-1:0]  pw_rx;
  logic [NPAC-1:0]  grant;

  pwd_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .byte_valid(byte_valid), .byte_data(byte_data), .busy(busy),
    .ack_valid(ack_valid), .ack(ack), .idx(idx), .pw_rx(pw_rx),
    .launch(launch), .rd_req(rd_req), .rd_addr(rd_addr), .dev_phase(dev_phase)
  );

  pwd_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_q_n), .launch(launch), .busy(busy), .done(done)
  );

  pwd_pac_store #(.NPAC(NPAC), .IDX_W(IDX_W), .PAC_W(PAC_W)) u_store (
    .clk(clk), .rst_n(rst_q_n), .launch(launch), .launch_idx(idx),
    .launch_match(pw_rx == pw_data), .done(done), .priv_clear(priv_clear),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .grant(grant)
  );

  assign pw_sel   = idx;
  assign wr_grant = grant[NSETS-1:0];
  assign rd_grant = grant[NPAC-1:NSETS];
endmodule

// File: rtl/pwd_verify_engine_chk.sv
module pwd_verify_engine_chk #(
  parameter int NSETS     = 8,
  parameter int WR_CYCLES = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             priv_clear,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             byte_valid,
  input logic             ack_valid,
  input logic             ack,
  input logic             rd_valid,
  input logic             busy,
  input logic             done,
  input logic             dev_phase,
  input logic [NSETS-1:0] rd_grant,
  input logic [NSETS-1:0] wr_grant
);
  localparam int RUN_W = $clog2(WR_CYCLES + 2);
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!busy) run_q <= '0;
    else run_q <= run_q + 1'b1;
  end

  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(byte_valid && !start_evt && !stop_evt));  // R3
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dev_phase && byte_valid && !start_evt && !stop_evt) |=> (ack_valid && !ack));  // R8
  AST_CLEAR_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    priv_clear |=> (rd_grant == '0 && wr_grant == '0));  // R11
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !priv_clear) |=> ($stable(rd_grant) && $stable(wr_grant)));  // R5
  AST_WR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RUN_W'(WR_CYCLES)));  // R4
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));  // R10
  AST_RD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(byte_valid));  // R9
endmodule

bind pwd_verify_engine pwd_verify_engine_chk #(.NSETS(NSETS), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .priv_clear(priv_clear), .start_evt(start_evt),
  .stop_evt(stop_evt), .byte_valid(byte_valid), .ack_valid(ack_valid), .ack(ack),
  .rd_valid(rd_valid), .busy(busy), .done(done), .dev_phase(dev_phase),
  .rd_grant(rd_grant), .wr_grant(wr_grant)
);

// File: tb/pwd_verify_engine_bench.sv
module pwd_verify_engine_bench;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic priv_clear = 1'b0, start_evt = 1'b0, stop_evt = 1'b0, byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        ack_valid, ack, rd_valid;
  logic [3:0]  pw_sel;
  logic [23:0] pw_data;
  logic [7:0]  rd_data, rd_grant, wr_grant;

  int n_chk = 0, n_err = 0;
  logic [7:0]  exp_pac [16];
  logic [15:0] exp_grant;

  always #10 clk = ~clk;

  function automatic logic [23:0] pw_of(input logic [3:0] i);
    return {8'h5A ^ {4'h0, i}, 8'hC3 + {4'h0, i}, {i, 4'h9}};
  endfunction

  assign pw_data = pw_of(pw_sel);

  pwd_verify_engine #(.WR_CYCLES(W)) u_pwd_verify_engine (
    .clk(clk), .rst_n(rst_n), .priv_clear(priv_clear), .start_evt(start_evt),
    .stop_evt(stop_evt), .byte_valid(byte_valid), .byte_data(byte_data),
    .ack_valid(ack_valid), .ack(ack), .pw_sel(pw_sel), .pw_data(pw_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic do_stop();
    stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b, input logic exp_ack, input string req);
    byte_valid = 1'b1; byte_data = b; @(negedge clk); byte_valid = 1'b0;
    chk(ack_valid === 1'b1 && ack === exp_ack, req, {ack_valid, ack}, {1'b1, exp_ack});
  endtask

  task automatic read_pac(input logic [3:0] i, input string req);
    do_start();
    do_byte(8'hB5, 1'b1, "R9");
    do_byte({4'hE, i}, 1'b1, "R9");
    chk(rd_valid === 1'b1 && rd_data === exp_pac[i], req, {rd_valid, rd_data}, {1'b1, exp_pac[i]});
    do_stop();
  endtask

  task automatic verify(input logic [3:0] i, input logic [23:0] pw);
    do_start();
    do_byte(8'hB4, 1'b1, "R2");
    do_byte({4'hA ^ i, i}, 1'b1, "R3");
    for (int k = 0; k < 3; k++) do_byte(pw[8*k +: 8], 1'b1, "R3");
    do_stop();
  endtask

  task automatic model_update(input logic [3:0] i, input logic ok);
    if (exp_pac[i] != 8'h00) begin
      if (ok) begin exp_pac[i] = 8'hFF; exp_grant[i] = 1'b1; end
      else exp_pac[i] = exp_pac[i] << 1;
    end
  endtask

  task automatic chk_grants(input string req);
    chk({rd_grant, wr_grant} === exp_grant, req, {rd_grant, wr_grant}, exp_grant);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_pac[i] = 8'hFF;
    exp_grant = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    chk(ack_valid === 1'b0 && rd_valid === 1'b0, "R1", {ack_valid, rd_valid}, 0);
    chk_grants("R1");
    for (int i = 0; i < 16; i++) read_pac(4'(i), "R1");

    // R5/R8/R9: correct password on every index
    for (int i = 0; i < 16; i++) begin
      verify(4'(i), pw_of(4'(i)));
      do_start();
      do_byte(8'hB5, 1'b0, "R8");
      do_stop();
      idle(W + 2);
      model_update(4'(i), 1'b1);
      read_pac(4'(i), "R5");
      chk_grants("R5");
    end

    // R11: privilege clear
    priv_clear = 1'b1; @(negedge clk); priv_clear = 1'b0;
    exp_grant = '0;
    chk_grants("R11");
    read_pac(4'd3, "R11");

    // R6 then R7: lockout of index 5
    for (int a = 0; a < 8; a++) begin
      verify(4'd5, pw_of(4'd5) ^ 24'h000100);
      idle(W + 2);
      model_update(4'd5, 1'b0);
      read_pac(4'd5, "R6");
    end
    verify(4'd5, pw_of(4'd5));
    idle(W + 2);
    model_update(4'd5, 1'b1);
    read_pac(4'd5, "R7");
    chk_grants("R7");

    // R10: abort after two password bytes
    do_start();
    do_byte(8'hB4, 1'b1, "R2");
    do_byte(8'h02, 1'b1, "R3");
    do_byte(8'h00, 1'b1, "R3");
    do_byte(8'h00, 1'b1, "R3");
    do_stop();
    do_start();
    do_byte(8'hB5, 1'b1, "R10");
    do_stop();
    read_pac(4'd2, "R10");

    // R2: unknown device byte
    do_start();
    do_byte(8'h33, 1'b0, "R2");
    do_byte(8'h00, 1'b0, "R2");
    do_stop();

    // R12: extra byte then stop still verifies
    do_start();
    do_byte(8'hB4, 1'b1, "R2");
    do_byte(8'h09, 1'b1, "R3");
    for (int k = 0; k < 3; k++) do_byte(pw_of(4'd9)[8*k +: 8], 1'b1, "R3");
    do_byte(8'h77, 1'b0, "R12");
    do_stop();
    // R8: command during busy; R4: last busy clock still NACK
    do_start();                    // edge P+1 (stop at P)
    do_byte(8'hB4, 1'b0, "R8");    // edge P+2
    do_stop();                     // P+3
    do_start();                    // P+4
    idle(W - 5);
    do_byte(8'hB5, 1'b0, "R4");    // edge P+W
    do_start();
    do_byte(8'hB5, 1'b1, "R4");
    do_stop();
    model_update(4'd9, 1'b1);
    read_pac(4'd9, "R12");
    chk_grants("R12");

    // R3: secure index 0111 is write password of set 7, wrong byte 2 fails
    verify(4'd7, pw_of(4'd7) ^ 24'h800000);
    idle(W + 2);
    model_update(4'd7, 1'b0);
    read_pac(4'd7, "R3");
    chk_grants("R3");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule